// File: doc/BRIEF.md
# Systematic Reed-Solomon Block Encoder

This block turns a serial stream of 8-bit message symbols into a systematic Reed-Solomon codeword. The code is a shortened (219,201) code over GF(2^8). It adds 18 check symbols, which is enough for a decoder to repair up to nine corrupted symbols. Each message symbol is copied to the output one cycle after it is accepted. The same symbol also drives a division register whose feedback taps are the coefficients of the generator polynomial. When the 201st symbol has gone in, the register holds the remainder, and that remainder is shifted out as the 18 check symbols.

The field uses the primitive polynomial x^8+x^4+x^3+x^2+1, with alpha = 0x02. The generator polynomial has degree 18. Its roots are alpha^1 through alpha^18. Its coefficients are computed at elaboration, and every tap is a fixed XOR network. An upstream source marks the first symbol of a block with a start flag and can pause between symbols. Output flags tell the two phases apart. A new block can begin on the cycle right after the last check symbol.

Top module: `rsEncoder`

## Requirements
- R1: Each codeword has 219 output symbols of 8 bits: first the 201 message symbols with `outIsData` high, then 18 check symbols with `outIsParity` high. The two flags are never high together, and `outValid` equals their OR.
- R2: A message symbol that is accepted on a clock edge appears unchanged on `outData` in the cycle after that edge, flagged as data.
- R3: Take the first output symbol of a codeword as the coefficient of x^218 and the last as the coefficient of x^0. Evaluated in GF(2^8) with x^8+x^4+x^3+x^2+1 (alpha = 0x02), that codeword is zero at every alpha^i for i = 1..18.
- R4: The 18 check symbols leave on 18 back-to-back cycles. The first of them follows directly after the cycle that shows the last message symbol.
- R5: When idle, a block begins only on a cycle where `inValid` and `inStart` are both high. A valid symbol without the start flag is ignored and produces no output.
- R6: Inside a block, a cycle with `inValid` low adds no symbol and produces no output. `inStart` has no effect in the data phase, so a symbol with it set counts as ordinary message data.
- R7: All inputs are ignored while check symbols are being sent.
- R8: A start presented while the last check symbol of a block is on the output is accepted. The second codeword meets R1 to R4 for its own data.
- R9: While `outValid` is low, `outData` and both flags are zero. This includes the state after reset.
- R10: An all-zero message gives 18 zero check symbols.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input symbol present this cycle |
| inStart | input | 1 | Marks the first symbol of a block |
| inData | input | 8 | Message symbol |
| outValid | output | 1 | Output symbol present this cycle |
| outData | output | 8 | Codeword symbol |
| outIsData | output | 1 | Output symbol is a copied message symbol |
| outIsParity | output | 1 | Output symbol is a check symbol |

## Verification
The bench checks the check symbols by evaluating every received codeword at all 18 generator roots. A wrong tap constant, a wrong field polynomial or a wrong feedback point makes at least one of these evaluations nonzero. It also drives bubbles inside a block, a stray start flag mid-block and junk inputs with start set during the check phase. A control unit that restarted or re-entered the data phase on any of these would give an output count or symbol order that no longer matches. Two blocks are sent with no gap, and the bench confirms that the second start, placed against the final check symbol, is neither dropped nor merged into the first block. An all-zero message and a message with a single trailing one pin down the zero remainder and the bare generator taps.

// File: rtl/rsEncPkg.sv
package rsEncPkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DATA   = 2'd1,
    ST_PARITY = 2'd2
  } encState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic takeData;     // load a message symbol through the divider
    logic firstData;    // treat the register as cleared for this symbol
    logic shiftParity;  // shift one check symbol out, feedback off
  } encStrobe_t;

  // product of two field elements, shift-and-add with reduction
  function automatic int gfMul(int a, int b, int symW, int poly);
    int acc;
    int x;
    acc = 0;
    x = a;
    for (int k = 0; k < symW; k++) begin
      if (((b >> k) & 1) != 0) acc = acc ^ x;
      x = x << 1;
      if (((x >> symW) & 1) != 0) x = x ^ poly;
    end
    return acc;
  endfunction

  // alpha (0x02) raised to a power
  function automatic int gfAlphaPow(int e, int symW, int poly);
    int v;
    v = 1;
    for (int k = 0; k < e; k++) v = gfMul(v, 2, symW, poly);
    return v;
  endfunction

  // coefficient idx of prod_{i=0}^{nPar-1} (x + alpha^(firstRoot+i))
  function automatic int genCoef(int idx, int nPar, int symW, int poly, int firstRoot);
    int g [256];
    int root;
    for (int k = 0; k < 256; k++) g[k] = 0;
    g[0] = 1;
    for (int i = 0; i < nPar; i++) begin
      root = gfAlphaPow(firstRoot + i, symW, poly);
      for (int j = i + 1; j >= 1; j--) g[j] = g[j-1] ^ gfMul(g[j], root, symW, poly);
      g[0] = gfMul(g[0], root, symW, poly);
    end
    return g[idx];
  endfunction

endpackage

// File: rtl/rsConstMul.sv
module rsConstMul #(
  parameter int SYM_W      = 8,
  parameter int FIELD_POLY = 285,
  parameter int COEF       = 1
) (
  input  logic [SYM_W-1:0] symIn,
  output logic [SYM_W-1:0] symOut
);

  logic [SYM_W-1:0] partial [SYM_W];

  // column j of the multiply matrix is COEF * x^j
  for (genvar j = 0; j < SYM_W; j++) begin : gCol
    localparam int COL = rsEncPkg::gfMul(COEF, 1 << j, SYM_W, FIELD_POLY);
    assign partial[j] = symIn[j] ? SYM_W'(COL) : '0;
  end

  always_comb begin
    symOut = '0;
    for (int j = 0; j < SYM_W; j++) symOut = symOut ^ partial[j];
  end

endmodule

// File: rtl/rsEncControl.sv
module rsEncControl
  import rsEncPkg::*;
#(
  parameter int K_DATA = 201,
  parameter int N_PAR  = 18
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inStart,
  output encStrobe_t strobe
);

  localparam int CNT_W = $clog2(K_DATA + 1);
  localparam int PAR_W = $clog2(N_PAR + 1);

  encState_t        state;
  logic [CNT_W-1:0] dataCnt;
  logic [PAR_W-1:0] parCnt;
  logic             lastData;
  logic             lastPar;

  assign lastData = (dataCnt == CNT_W'(K_DATA - 1));
  assign lastPar  = (parCnt == PAR_W'(N_PAR - 1));

  always_comb begin
    strobe = '0;
    unique case (state)
      ST_IDLE: begin
        strobe.takeData  = inValid && inStart;
        strobe.firstData = inValid && inStart;
      end
      ST_DATA:   strobe.takeData    = inValid;
      ST_PARITY: strobe.shiftParity = 1'b1;
      default:   strobe = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      dataCnt <= '0;
      parCnt  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (strobe.takeData) begin
            dataCnt <= CNT_W'(1);
            parCnt  <= '0;
            state   <= (K_DATA == 1) ? ST_PARITY : ST_DATA;
          end
        end
        ST_DATA: begin
          if (inValid) begin
            if (lastData) begin
              state  <= ST_PARITY;
              parCnt <= '0;
            end else begin
              dataCnt <= dataCnt + CNT_W'(1);
            end
          end
        end
        ST_PARITY: begin
          if (lastPar) state <= ST_IDLE;
          else         parCnt <= parCnt + PAR_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rsEncDatapath.sv
module rsEncDatapath
  import rsEncPkg::*;
#(
  parameter int SYM_W      = 8,
  parameter int N_PAR      = 18,
  parameter int FIELD_POLY = 285,
  parameter int FIRST_ROOT = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  encStrobe_t       strobe,
  input  logic [SYM_W-1:0] inData,
  output logic             outValid,
  output logic [SYM_W-1:0] outData,
  output logic             outIsData,
  output logic             outIsParity
);

  logic [SYM_W-1:0] stage    [N_PAR];
  logic [SYM_W-1:0] tapProd  [N_PAR];
  logic [SYM_W-1:0] nextData [N_PAR];
  logic [SYM_W-1:0] topStage;
  logic [SYM_W-1:0] feedback;

  // a block start sees an empty register
  assign topStage = strobe.firstData ? '0 : stage[N_PAR-1];
  assign feedback = inData ^ topStage;

  for (genvar i = 0; i < N_PAR; i++) begin : gTap
    localparam int G_I = genCoef(i, N_PAR, SYM_W, FIELD_POLY, FIRST_ROOT);
    rsConstMul #(
      .SYM_W     (SYM_W),
      .FIELD_POLY(FIELD_POLY),
      .COEF      (G_I)
    ) uMul (
      .symIn (feedback),
      .symOut(tapProd[i])
    );
    if (i == 0) begin : gLow
      assign nextData[i] = tapProd[i];
    end else begin : gMid
      assign nextData[i] = (strobe.firstData ? '0 : stage[i-1]) ^ tapProd[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N_PAR; i++) stage[i] <= '0;
      outValid    <= 1'b0;
      outData     <= '0;
      outIsData   <= 1'b0;
      outIsParity <= 1'b0;
    end else if (strobe.takeData) begin
      for (int i = 0; i < N_PAR; i++) stage[i] <= nextData[i];
      outValid    <= 1'b1;
      outData     <= inData;
      outIsData   <= 1'b1;
      outIsParity <= 1'b0;
    end else if (strobe.shiftParity) begin
      stage[0] <= '0;
      for (int i = 1; i < N_PAR; i++) stage[i] <= stage[i-1];
      outValid    <= 1'b1;
      outData     <= stage[N_PAR-1];
      outIsData   <= 1'b0;
      outIsParity <= 1'b1;
    end else begin
      outValid    <= 1'b0;
      outData     <= '0;
      outIsData   <= 1'b0;
      outIsParity <= 1'b0;
    end
  end

endmodule

// File: rtl/rsEncoder.sv
module rsEncoder
  import rsEncPkg::*;
#(
  parameter int SYM_W      = 8,
  parameter int N_TOTAL    = 219,
  parameter int K_DATA     = 201,
  parameter int FIELD_POLY = 285,
  parameter int FIRST_ROOT = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inStart,
  input  logic [SYM_W-1:0] inData,
  output logic             outValid,
  output logic [SYM_W-1:0] outData,
  output logic             outIsData,
  output logic             outIsParity
);

  localparam int N_PAR = N_TOTAL - K_DATA;

  encStrobe_t strobe;

  rsEncControl #(
    .K_DATA(K_DATA),
    .N_PAR (N_PAR)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .inStart(inStart),
    .strobe (strobe)
  );

  rsEncDatapath #(
    .SYM_W     (SYM_W),
    .N_PAR     (N_PAR),
    .FIELD_POLY(FIELD_POLY),
    .FIRST_ROOT(FIRST_ROOT)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .inData     (inData),
    .outValid   (outValid),
    .outData    (outData),
    .outIsData  (outIsData),
    .outIsParity(outIsParity)
  );

endmodule

// File: rtl/rsEncChecker.sv
module rsEncChecker #(
  parameter int SYM_W  = 8,
  parameter int K_DATA = 201,
  parameter int N_PAR  = 18
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [SYM_W-1:0] inData,
  input logic             outValid,
  input logic [SYM_W-1:0] outData,
  input logic             outIsData,
  input logic             outIsParity
);

  int dataSeen;
  int parSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataSeen <= 0;
      parSeen  <= 0;
    end else begin
      if (outIsParity)    dataSeen <= 0;
      else if (outIsData) dataSeen <= dataSeen + 1;
      if (outIsParity) parSeen <= parSeen + 1;
      else             parSeen <= 0;
    end
  end

  p_flags_excl_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(outIsData && outIsParity) && (outValid == (outIsData || outIsParity)));

  p_echo_r2: assert property (@(posedge clk) disable iff (!rstN)
    outIsData |-> ($past(inValid) && outData == $past(inData)));

  p_data_count_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outIsParity) |-> dataSeen == K_DATA);

  p_parity_follows_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outIsParity) |-> $past(outIsData));

  p_parity_run_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outIsParity) |-> parSeen == N_PAR);

  p_parity_gapless_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outIsParity && parSeen < N_PAR - 1) |=> outIsParity);

  p_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (outData == '0));

endmodule

bind rsEncoder rsEncChecker #(
  .SYM_W (SYM_W),
  .K_DATA(K_DATA),
  .N_PAR (N_TOTAL - K_DATA)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .inData     (inData),
  .outValid   (outValid),
  .outData    (outData),
  .outIsData  (outIsData),
  .outIsParity(outIsParity)
);

// File: tb/tb_rsEncoder.sv
`timescale 1ns/1ps
module tb_rsEncoder;

  localparam int K_DATA  = 201;
  localparam int N_TOTAL = 219;
  localparam int N_PAR   = N_TOTAL - K_DATA;
  localparam int CAP     = 1024;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic       inStart = 1'b0;
  logic [7:0] inData = 8'h00;
  logic       outValid;
  logic [7:0] outData;
  logic       outIsData;
  logic       outIsParity;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int capCnt = 0;
  int quietBad = 0;
  logic [7:0] capData [CAP];
  bit         capIsD  [CAP];
  bit         capIsP  [CAP];
  int         capCyc  [CAP];
  int         startCyc [4];

  always #4 clk = ~clk;

  rsEncoder dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inStart(inStart), .inData(inData),
    .outValid(outValid), .outData(outData), .outIsData(outIsData), .outIsParity(outIsParity)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rstN) begin
      if (outValid) begin
        if (capCnt < CAP) begin
          capData[capCnt] = outData;
          capIsD[capCnt]  = outIsData;
          capIsP[capCnt]  = outIsParity;
          capCyc[capCnt]  = cyc;
        end
        capCnt = capCnt + 1;
      end else if (outData != 8'h00 || outIsData || outIsParity) begin
        quietBad = quietBad + 1;
      end
    end
  end

  function automatic logic [7:0] tbMul(logic [7:0] a, logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] x;
    acc = 8'h00;
    x = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) acc = acc ^ x;
      x = x[7] ? ((x << 1) ^ 8'h1D) : (x << 1);
    end
    return acc;
  endfunction

  function automatic logic [7:0] patByte(int kind, int i);
    case (kind)
      0: return 8'h00;
      1: return 8'((i + 1) & 255);
      2: return (i == K_DATA - 1) ? 8'h01 : 8'h00;
      3: return 8'(((i * 37 + 11) ^ (i >> 3)) & 255);
      default: return 8'hFF;
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idleCycles(int n);
    repeat (n) begin
      @(negedge clk);
      inValid = 1'b0;
      inStart = 1'b0;
      inData  = 8'h00;
    end
  endtask

  task automatic sendBlock(int kind, bit gaps, bit junk, bit midStart, int slot);
    for (int i = 0; i < K_DATA; i++) begin
      if (gaps && (i % 7 == 3)) begin
        @(negedge clk);
        inValid = 1'b0;
        inStart = 1'b1;
        inData  = 8'hA5;
      end
      @(negedge clk);
      inValid = 1'b1;
      inStart = (i == 0) || (midStart && i == 100);
      inData  = patByte(kind, i);
      if (i == 0) startCyc[slot] = cyc;
    end
    repeat (N_PAR) begin
      @(negedge clk);
      inValid = junk;
      inStart = junk;
      inData  = junk ? 8'h5A : 8'h00;
    end
  endtask

  // data echo (R1, R2), check-symbol timing (R4) and root evaluation (R3)
  task automatic checkBlock(int base, int kind, int slot, string tag);
    int badData;
    int badFlag;
    int badGap;
    int badSyn;
    logic [7:0] root;
    logic [7:0] s;
    badData = 0; badFlag = 0; badGap = 0; badSyn = 0;
    for (int i = 0; i < K_DATA; i++) begin
      if (capData[base+i] != patByte(kind, i)) badData++;
      if (!capIsD[base+i] || capIsP[base+i]) badFlag++;
    end
    for (int j = 0; j < N_PAR; j++) begin
      if (capIsD[base+K_DATA+j] || !capIsP[base+K_DATA+j]) badFlag++;
      if (capCyc[base+K_DATA+j] != capCyc[base+K_DATA-1] + 1 + j) badGap++;
    end
    check(badData == 0, "R2", {tag, " message symbols copied"}, badData, 0);
    check(badFlag == 0, "R1", {tag, " phase flags"}, badFlag, 0);
    check(capCyc[base] == startCyc[slot] + 1, "R2", {tag, " first symbol latency"},
          capCyc[base] - startCyc[slot], 1);
    check(badGap == 0, "R4", {tag, " check symbols consecutive"}, badGap, 0);
    root = 8'h01;
    for (int r = 1; r <= N_PAR; r++) begin
      root = tbMul(root, 8'h02);
      s = 8'h00;
      for (int i = 0; i < N_TOTAL; i++) s = tbMul(s, root) ^ capData[base+i];
      if (s != 8'h00) badSyn++;
    end
    check(badSyn == 0, "R3", {tag, " roots alpha^1..alpha^18 nonzero count"}, badSyn, 0);
  endtask

  task automatic testReset();
    check(outValid == 1'b0 && outIsData == 1'b0 && outIsParity == 1'b0, "R9",
          "flags after reset", {outValid, outIsData, outIsParity}, 0);
    check(outData == 8'h00, "R9", "data after reset", outData, 0);
  endtask

  task automatic testZeroMessage();
    int nz;
    capCnt = 0;
    sendBlock(0, 1'b0, 1'b0, 1'b0, 0);
    idleCycles(3);
    check(capCnt == N_TOTAL, "R1", "zero block symbol count", capCnt, N_TOTAL);
    checkBlock(0, 0, 0, "zero");
    nz = 0;
    for (int j = 0; j < N_PAR; j++) if (capData[K_DATA+j] != 8'h00) nz++;
    check(nz == 0, "R10", "zero message check symbols nonzero count", nz, 0);
  endtask

  task automatic testPattern(int kind, string tag);
    capCnt = 0;
    sendBlock(kind, 1'b0, 1'b0, 1'b0, 0);
    idleCycles(3);
    check(capCnt == N_TOTAL, "R1", {tag, " symbol count"}, capCnt, N_TOTAL);
    checkBlock(0, kind, 0, tag);
  endtask

  task automatic testGaps();
    capCnt = 0;
    sendBlock(4, 1'b1, 1'b0, 1'b0, 0);
    idleCycles(3);
    check(capCnt == N_TOTAL, "R6", "bubbles add no output", capCnt, N_TOTAL);
    checkBlock(0, 4, 0, "gaps");
  endtask

  task automatic testMidStart();
    capCnt = 0;
    sendBlock(3, 1'b0, 1'b0, 1'b1, 0);
    idleCycles(3);
    check(capCnt == N_TOTAL, "R6", "stray start mid-block count", capCnt, N_TOTAL);
    checkBlock(0, 3, 0, "midstart");
  endtask

  task automatic testJunkParity();
    capCnt = 0;
    sendBlock(3, 1'b0, 1'b1, 1'b0, 0);
    idleCycles(5);
    check(capCnt == N_TOTAL, "R7", "inputs during check phase ignored", capCnt, N_TOTAL);
    checkBlock(0, 3, 0, "junk");
  endtask

  task automatic testNoStart();
    capCnt = 0;
    repeat (4) begin
      @(negedge clk);
      inValid = 1'b1;
      inStart = 1'b0;
      inData  = 8'h77;
    end
    idleCycles(3);
    check(capCnt == 0, "R5", "symbols without start produce output", capCnt, 0);
  endtask

  task automatic testBackToBack();
    capCnt = 0;
    sendBlock(1, 1'b0, 1'b0, 1'b0, 0);
    sendBlock(3, 1'b0, 1'b0, 1'b0, 1);
    idleCycles(3);
    check(capCnt == 2 * N_TOTAL, "R8", "two blocks symbol count", capCnt, 2 * N_TOTAL);
    check(capCyc[N_TOTAL] == capCyc[N_TOTAL-1] + 1, "R8", "second start follows last check symbol",
          capCyc[N_TOTAL] - capCyc[N_TOTAL-1], 1);
    checkBlock(0, 1, 0, "b2b-first");
    checkBlock(N_TOTAL, 3, 1, "b2b-second");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors = errors + 1;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idleCycles(4);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testZeroMessage();
    testPattern(1, "ramp");
    testPattern(2, "trailing-one");
    testGaps();
    testMidStart();
    testJunkParity();
    testNoStart();
    testBackToBack();
    check(quietBad == 0, "R9", "idle cycles with nonzero data or flags", quietBad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule